// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor core built around one accumulator. It fetches 16-bit instructions from a single memory through one address bus and one data path, decodes them and executes them over two or three clock steps. A 2-bit step counter, together with the mode and opcode fields of the held instruction, produces every control signal. The datapath registers are a program counter, an instruction register, a pointer register for indirect operands, the accumulator and a three-bit flag register.

Each instruction word has three fields. The two top bits select how the operand is found. The next four bits give the opcode. The low ten bits hold an address, a literal value or a shift count. When the mode field is 11, the opcode selects an operation that works only on the accumulator, the flags or the program counter. Conditional branches use the upper half of the opcode space. Memory is outside the core. It returns read data in the same cycle as the address and takes a write at the clock edge.

Top module: `acc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the core reads memory (enable 1, mem_rw 1, drive 0) at address 0. Asserting reset in the middle of a program returns the program counter to 0.
- R2: Every instruction starts with a read at the program counter address into the instruction register. The word layout is mode in bits 15:14, opcode in bits 13:10 and field in bits 9:0. The program counter does not change during the fetch cycle.
- R3: Instructions in direct, immediate and accumulator-only mode take 2 cycles. Instructions in indirect mode take 3 cycles.
- R4: In the memory modes, opcodes 0000 to 0101 are load, and, or, xor, add and sub. The operand is the word at the field address (mode 00), the zero-extended field (mode 10), or the word at the address held in memory at the field address (mode 01). N is set from bit 15 of the result and Z from a zero result. O is the signed overflow of add and sub, and is 0 for the other operations.
- R5: Opcode 0110 (compare) sets the flags as a subtraction of the operand from the accumulator would, and leaves the accumulator unchanged.
- R6: In indirect mode, the step after fetch reads the field address into the pointer register. The following step uses the low 10 bits of that word as the address.
- R7: Opcode 0111 writes the accumulator to memory with mem_rw 0 and the drive enable 1, in direct or indirect mode. In immediate mode it changes nothing and only advances the program counter.
- R8: Opcodes 1000 to 1111 branch when their condition holds. The conditions, in opcode order, are: always; O; Z; not Z; N and not Z; N or Z; neither N nor Z; not N or Z.
- R9: The branch target is the field in direct and immediate mode. In indirect mode it is the low 10 bits of the word read from memory. A branch that is not taken advances the program counter by one.
- R10: In mode 11, opcode 0001 sets the accumulator to all ones, 0010 inverts it and 0011 negates it (two's complement). Each updates N and Z. O is 0, except that negating 0x8000 sets O.
- R11: In mode 11, opcode 0100 shifts left and 0101 shifts right, by the low 4 field bits, filling with zeros. O receives the last bit shifted out, or 0 for a count of 0. N and Z follow the result.
- R12: The flag word places N at bit 2, Z at bit 1 and O at bit 0. Mode-11 opcode 0110 loads the flags from accumulator bits 2:0. Opcode 0111 loads the accumulator with the zero-extended flag word.
- R13: Mode-11 opcode 1000 loads the program counter from the low accumulator bits. Opcode 1001 loads the accumulator with the address of the executing instruction.
- R14: Mode-11 opcodes 0000 and 1010 to 1111 make no memory access and only advance the program counter. The drive enable is never high during a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 10 | Memory word address |
| mem_en | output | 1 | Memory access enable |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_drv | output | 1 | Data drive enable for writes |
| mem_rdata | input | 16 | Read data, valid in the same cycle |

## Verification
The bench builds the core with its default 16-bit word, which gives a 10-bit address field and a 4-bit shift count. That size is small enough to sweep exhaustively the features that matter. It runs all 64 pairings of flag value and branch condition in each of the three operand modes. It shifts left and right by every count from 0 to 15. It tries each memory-mode operation in each operand mode on sign-boundary operand pairs. A Fibonacci loop that stores through a pointer, together with a short program of copies and no-ops, covers the register transfers. Cycle spacing between stores is used to check how long each instruction takes.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;
  typedef enum logic [1:0] {MD_DIR = 2'b00, MD_IND = 2'b01, MD_IMM = 2'b10, MD_ACC = 2'b11} mode_e;
  typedef enum logic [1:0] {AS_PC = 2'd0, AS_FIELD = 2'd1, AS_PTR = 2'd2} asel_e;
  typedef enum logic [1:0] {PS_FIELD = 2'd0, PS_PTR = 2'd1, PS_ACC = 2'd2} psel_e;
  typedef enum logic [3:0] {
    AL_LOAD, AL_AND, AL_OR, AL_XOR, AL_ADD, AL_SUB, AL_CMP, AL_SET,
    AL_NOT, AL_NEG, AL_SHL, AL_SHR, AL_A2F, AL_F2A, AL_PC2A, AL_HOLD
  } alu_op_e;
  typedef struct packed { logic n; logic z; logic o; } flags_t;
  typedef struct packed {
    asel_e   asel;
    logic    mem_en;
    logic    mem_rd;
    logic    drv;
    logic    ir_en;
    logic    ptr_en;
    logic    acc_en;
    logic    flg_en;
    logic    pc_inc;
    logic    pc_ld;
    psel_e   psel;
    alu_op_e alu_op;
  } ctl_t;
endpackage

// File: rtl/acc_rst_sync.sv
`timescale 1ns/1ps
module acc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end
  assign srst_n = s2_q;
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu import acc_pkg::*; #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [AW-1:0] pc,
  input  flags_t        fi,
  output logic [DW-1:0] res,
  output flags_t        fo
);
  localparam int M  = DW - 1;
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sum, dif, nzv;
  logic [DW:0]   wl, wr;
  logic          ov;

  assign sum = a + b;
  assign dif = a - b;
  assign wl  = {1'b0, a} << b[CW-1:0];
  assign wr  = {a, 1'b0} >> b[CW-1:0];

  always_comb begin
    res = a;
    nzv = a;
    ov  = 1'b0;
    case (op)
      AL_LOAD: res = b;
      AL_AND:  res = a & b;
      AL_OR:   res = a | b;
      AL_XOR:  res = a ^ b;
      AL_ADD:  begin res = sum; ov = (a[M] == b[M]) && (sum[M] != a[M]); end
      AL_SUB:  begin res = dif; ov = (a[M] != b[M]) && (dif[M] != a[M]); end
      AL_CMP:  ov = (a[M] != b[M]) && (dif[M] != a[M]);
      AL_SET:  res = '1;
      AL_NOT:  res = ~a;
      AL_NEG:  begin res = -a; ov = a[M] & res[M]; end
      AL_SHL:  begin res = wl[DW-1:0]; ov = wl[DW]; end
      AL_SHR:  begin res = wr[DW:1]; ov = wr[0]; end
      AL_F2A:  res = {{(DW-3){1'b0}}, fi};
      AL_PC2A: res = {{(DW-AW){1'b0}}, pc};
      default: res = a;
    endcase
    nzv = (op == AL_CMP) ? dif : res;
    fo  = '{n: nzv[M], z: (nzv == '0), o: ov};
    if (op == AL_A2F) fo = flags_t'(a[2:0]);
  end
endmodule

// File: rtl/acc_seq.sv
`timescale 1ns/1ps
module acc_seq import acc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  mode_e      mode,
  input  logic [3:0] opc,
  input  flags_t     flg,
  output ctl_t       ctl
);
  logic [1:0] step_q, step_d;
  logic       ex, ex_imm, cond_ok;
  asel_e      ex_as;
  psel_e      ex_ps;

  always_comb begin
    case (opc[2:0])
      3'd0:    cond_ok = 1'b1;
      3'd1:    cond_ok = flg.o;
      3'd2:    cond_ok = flg.z;
      3'd3:    cond_ok = !flg.z;
      3'd4:    cond_ok = flg.n && !flg.z;
      3'd5:    cond_ok = flg.n || flg.z;
      3'd6:    cond_ok = !flg.n && !flg.z;
      default: cond_ok = !flg.n || flg.z;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.asel   = AS_PC;
    ctl.psel   = PS_FIELD;
    ctl.alu_op = AL_HOLD;
    step_d     = 2'd0;
    ex         = 1'b0;
    ex_as      = AS_FIELD;
    ex_ps      = PS_FIELD;
    ex_imm     = (mode == MD_IMM);
    case (step_q)
      2'd0: begin
        ctl.mem_en = 1'b1;
        ctl.mem_rd = 1'b1;
        ctl.ir_en  = 1'b1;
        step_d     = 2'd1;
      end
      2'd1: begin
        if (mode == MD_ACC) begin
          ctl.pc_inc = 1'b1;
          case (opc)
            4'b0001: begin ctl.alu_op = AL_SET;  ctl.acc_en = 1'b1; ctl.flg_en = 1'b1; end
            4'b0010: begin ctl.alu_op = AL_NOT;  ctl.acc_en = 1'b1; ctl.flg_en = 1'b1; end
            4'b0011: begin ctl.alu_op = AL_NEG;  ctl.acc_en = 1'b1; ctl.flg_en = 1'b1; end
            4'b0100: begin ctl.alu_op = AL_SHL;  ctl.acc_en = 1'b1; ctl.flg_en = 1'b1; end
            4'b0101: begin ctl.alu_op = AL_SHR;  ctl.acc_en = 1'b1; ctl.flg_en = 1'b1; end
            4'b0110: begin ctl.alu_op = AL_A2F;  ctl.flg_en = 1'b1; end
            4'b0111: begin ctl.alu_op = AL_F2A;  ctl.acc_en = 1'b1; end
            4'b1000: begin ctl.pc_inc = 1'b0; ctl.pc_ld = 1'b1; ctl.psel = PS_ACC; end
            4'b1001: begin ctl.alu_op = AL_PC2A; ctl.acc_en = 1'b1; end
            default: ;
          endcase
        end else if (mode == MD_IND) begin
          ctl.asel   = AS_FIELD;
          ctl.mem_en = 1'b1;
          ctl.mem_rd = 1'b1;
          ctl.ptr_en = 1'b1;
          step_d     = 2'd2;
        end else begin
          ex = 1'b1;
        end
      end
      2'd2: begin
        ex    = 1'b1;
        ex_as = AS_PTR;
        ex_ps = PS_PTR;
      end
      default: ;
    endcase
    if (ex) begin
      ctl.asel   = ex_as;
      ctl.pc_inc = 1'b1;
      if (!opc[3]) begin
        if (opc == 4'b0111) begin
          if (!ex_imm) begin
            ctl.mem_en = 1'b1;
            ctl.drv    = 1'b1;
          end
        end else begin
          ctl.alu_op = alu_op_e'({1'b0, opc[2:0]});
          ctl.mem_en = !ex_imm;
          ctl.mem_rd = !ex_imm;
          ctl.acc_en = (opc != 4'b0110);
          ctl.flg_en = 1'b1;
        end
      end else if (cond_ok) begin
        ctl.pc_inc = 1'b0;
        ctl.pc_ld  = 1'b1;
        ctl.psel   = ex_ps;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 2'd0;
    else        step_q <= step_d;
  end

  // R3: step 3 is never reached; short instructions end after one execute step
  p_step_legal_r3: assert property (@(posedge clk) disable iff (!rst_n) step_q != 2'd3);
  p_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == 2'd1 && mode != MD_IND) |=> step_q == 2'd0);
  p_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_q == 2'd2 |=> step_q == 2'd0);
  // R6: the third step only follows an indirect pointer read
  p_ind_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_q == 2'd2 |-> ($past(step_q) == 2'd1 && $past(mode) == MD_IND));
endmodule

// File: rtl/acc_core.sv
`timescale 1ns/1ps
module acc_core import acc_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-7:0] mem_addr,
  output logic          mem_en,
  output logic          mem_rw,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_drv,
  input  logic [DW-1:0] mem_rdata
);
  localparam int AW = DW - 6;

  logic          srst_n;
  logic [AW-1:0] pc_q, pc_d, ptr_q, ptr_d, field;
  logic [DW-1:0] ir_q, ir_d, acc_q, acc_d, opnd, alu_res;
  flags_t        flg_q, flg_d, alu_flg;
  mode_e         mode;
  logic [3:0]    opc;
  ctl_t          ctl;

  acc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign mode  = mode_e'(ir_q[DW-1 -: 2]);
  assign opc   = ir_q[DW-3 -: 4];
  assign field = ir_q[AW-1:0];

  acc_seq u_seq (
    .clk(clk), .rst_n(srst_n), .mode(mode), .opc(opc), .flg(flg_q), .ctl(ctl)
  );

  assign opnd = (mode == MD_DIR || mode == MD_IND) ? mem_rdata
                                                   : {{(DW-AW){1'b0}}, field};

  acc_alu #(.DW(DW), .AW(AW)) u_alu (
    .op(ctl.alu_op), .a(acc_q), .b(opnd), .pc(pc_q), .fi(flg_q),
    .res(alu_res), .fo(alu_flg)
  );

  always_comb begin
    case (ctl.asel)
      AS_FIELD: mem_addr = field;
      AS_PTR:   mem_addr = ptr_q;
      default:  mem_addr = pc_q;
    endcase
  end

  assign mem_en    = ctl.mem_en;
  assign mem_rw    = ctl.mem_rd;
  assign mem_drv   = ctl.drv;
  assign mem_wdata = acc_q;

  always_comb begin
    pc_d = pc_q;
    if (ctl.pc_ld) begin
      case (ctl.psel)
        PS_PTR:  pc_d = ptr_q;
        PS_ACC:  pc_d = acc_q[AW-1:0];
        default: pc_d = field;
      endcase
    end else if (ctl.pc_inc) begin
      pc_d = pc_q + 1'b1;
    end
    ir_d  = ctl.ir_en  ? mem_rdata           : ir_q;
    ptr_d = ctl.ptr_en ? mem_rdata[AW-1:0]   : ptr_q;
    acc_d = ctl.acc_en ? alu_res             : acc_q;
    flg_d = ctl.flg_en ? alu_flg             : flg_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      ptr_q <= '0;
      acc_q <= '0;
      flg_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      ptr_q <= ptr_d;
      acc_q <= acc_d;
      flg_q <= flg_d;
    end
  end

  // R14: a read never has the data drive enabled
  p_no_drive_read_r14: assert property (@(posedge clk) disable iff (!srst_n)
    (mem_en && mem_rw) |-> !mem_drv);
  // R7: driving data only happens in a write access
  p_drive_write_r7: assert property (@(posedge clk) disable iff (!srst_n)
    mem_drv |-> (mem_en && !mem_rw));
  // R2: the program counter holds across a fetch
  p_fetch_holds_pc_r2: assert property (@(posedge clk) disable iff (!srst_n)
    ctl.ir_en |=> (pc_q == $past(pc_q)));
  // R6: the indirect operand address is the word read one cycle earlier
  p_ptr_from_bus_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (ctl.asel == AS_PTR) |-> (mem_addr == $past(mem_rdata[AW-1:0])));
endmodule

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int DONE_A = 1023;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_en, mem_rw, mem_drv;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] mem [0:1023];
  logic [DW-1:0] img [0:1023];
  int cyc = 0, n_done = 0, t300 = 0, t301 = 0;
  int total = 0, bad = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;  // 8 ns period

  acc_core #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_en(mem_en), .mem_rw(mem_rw),
    .mem_wdata(mem_wdata), .mem_drv(mem_drv), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= img[i];
    end else if (mem_en && !mem_rw && mem_drv) begin
      mem[mem_addr] <= mem_wdata;
      if (mem_addr == 10'(DONE_A)) n_done <= n_done + 1;
      if (mem_addr == 10'd300) t300 <= cyc;
      if (mem_addr == 10'd301) t301 <= cyc;
    end
  end

  function automatic logic [15:0] ins(int m, int op, int f);
    logic [1:0] mm = m[1:0];
    logic [3:0] oo = op[3:0];
    logic [9:0] ff = f[9:0];
    return {mm, oo, ff};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic begin_run();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) img[i] = '0;
  endtask

  task automatic run_to_done(string req);
    int d0;
    logic hit;
    d0 = n_done;
    hit = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (n_done != d0) begin hit = 1'b1; break; end
    end
    check(req, hit, 1'b1, "program reached its end marker");
  endtask

  task automatic go(string req);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_to_done(req);
  endtask

  // memory-mode reference: {n,z,o,result}
  function automatic logic [18:0] ref_mem(int op, logic [15:0] a, logic [15:0] b);
    logic [15:0] r, v;
    logic o;
    r = a; v = a; o = 1'b0;
    case (op)
      0: begin r = b; v = b; end
      1: begin r = a & b; v = r; end
      2: begin r = a | b; v = r; end
      3: begin r = a ^ b; v = r; end
      4: begin r = a + b; v = r; o = (a[15] == b[15]) && (r[15] != a[15]); end
      5: begin r = a - b; v = r; o = (a[15] != b[15]) && (r[15] != a[15]); end
      default: begin v = a - b; r = a; o = (a[15] != b[15]) && (v[15] != a[15]); end
    endcase
    return {v[15], v == 16'h0, o, r};
  endfunction

  function automatic logic [18:0] ref_acc(int op, logic [15:0] a, int k);
    logic [15:0] r;
    logic o;
    o = 1'b0;
    case (op)
      1: r = 16'hFFFF;
      2: r = ~a;
      3: begin r = 16'h0 - a; o = (a == 16'h8000); end
      4: begin r = a << k; o = (k != 0) ? a[16-k] : 1'b0; end
      default: begin r = a >> k; o = (k != 0) ? a[k-1] : 1'b0; end
    endcase
    return {r[15], r == 16'h0, o, r};
  endfunction

  function automatic logic ref_cond(int c, logic [2:0] f);
    logic n, z, o;
    {n, z, o} = f;
    case (c)
      0: return 1'b1;
      1: return o;
      2: return z;
      3: return !z;
      4: return n && !z;
      5: return n || z;
      6: return !n && !z;
      default: return !n || z;
    endcase
  endfunction

  initial begin
    logic [15:0] vals [6];
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

    // R1: reset state
    begin_run();
    @(negedge clk);
    check("R1", {mem_en, mem_rw, mem_drv}, 3'b110, "bus during reset");
    check("R1", mem_addr, 0, "address during reset");

    // R3 R4 R5 R6 R7: memory-mode operations in three operand modes
    for (int m = 0; m < 3; m++) begin
      for (int op = 0; op < 7; op++) begin
        for (int ia = 0; ia < 6; ia++) begin
          for (int ib = 0; ib < 6; ib++) begin
            logic [15:0] a, b, bo;
            logic [18:0] e;
            string rq;
            a = vals[ia]; b = vals[ib];
            bo = (m == 2) ? {6'b0, b[9:0]} : b;
            e = ref_mem(op, a, bo);
            rq = (op == 6) ? "R5" : ((m == 1) ? "R6" : "R4");
            begin_run();
            img[0] = ins(0, 0, 200);
            img[1] = ins(0, 7, 300);
            img[2] = ins(m, op, (m == 1) ? 202 : ((m == 2) ? int'(b[9:0]) : 201));
            img[3] = ins(0, 7, 301);
            img[4] = ins(3, 7, 0);
            img[5] = ins(0, 7, 302);
            img[6] = ins(2, 0, 1);
            img[7] = ins(0, 7, DONE_A);
            img[8] = ins(2, 8, 8);
            img[200] = a; img[201] = b; img[202] = 16'd201;
            go(rq);
            check("R7", mem[300], a, "stored accumulator");
            check(rq, mem[301], e[15:0], "operation result");
            check(rq, mem[302], {13'b0, e[18:16]}, "flag word");
            check("R3", t301 - t300, (m == 1) ? 5 : 4, "store spacing");
          end
        end
      end
    end

    // R8 R9: every flag value against every condition, each mode
    for (int m = 0; m < 3; m++) begin
      for (int v = 0; v < 8; v++) begin
        for (int c = 0; c < 8; c++) begin
          begin_run();
          img[0] = ins(2, 0, v);
          img[1] = ins(3, 6, 0);
          img[2] = ins(m, 8 + c, (m == 1) ? 500 : 16);
          img[3] = ins(2, 0, 1);
          img[4] = ins(0, 7, 400);
          img[5] = ins(2, 0, 1);
          img[6] = ins(0, 7, DONE_A);
          img[7] = ins(2, 8, 7);
          img[16] = ins(2, 0, 2);
          img[17] = ins(0, 7, 400);
          img[18] = ins(2, 0, 1);
          img[19] = ins(0, 7, DONE_A);
          img[20] = ins(2, 8, 20);
          img[500] = 16'hFC10;
          go("R8");
          check((m == 1) ? "R9" : "R8", mem[400],
                ref_cond(c, v[2:0]) ? 16'd2 : 16'd1, "branch outcome");
        end
      end
    end

    // R10 R11: accumulator-only arithmetic and every shift count
    for (int ia = 0; ia < 6; ia++) begin
      for (int op = 1; op < 6; op++) begin
        for (int k = 0; k < ((op >= 4) ? 16 : 1); k++) begin
          logic [18:0] e;
          e = ref_acc(op, vals[ia], k);
          begin_run();
          img[0] = ins(0, 0, 200);
          img[1] = ins(3, op, 10'h2D0 | k);
          img[2] = ins(0, 7, 301);
          img[3] = ins(3, 7, 0);
          img[4] = ins(0, 7, 302);
          img[5] = ins(2, 0, 1);
          img[6] = ins(0, 7, DONE_A);
          img[7] = ins(2, 8, 7);
          img[200] = vals[ia];
          go((op >= 4) ? "R11" : "R10");
          check((op >= 4) ? "R11" : "R10", mem[301], e[15:0], "accumulator result");
          check((op >= 4) ? "R11" : "R10", mem[302], {13'b0, e[18:16]}, "flag word");
        end
      end
    end

    // R12 R13 R14 R2 R1: copies, no-ops, restart at 0 after a mid-run reset
    begin_run();
    img[0]  = ins(3, 0, 0);
    img[1]  = ins(3, 10, 0);
    img[2]  = ins(2, 7, 300);
    img[3]  = ins(3, 9, 0);
    img[4]  = ins(0, 7, 301);
    img[5]  = ins(2, 0, 9);
    img[6]  = ins(3, 8, 0);
    img[7]  = ins(2, 0, 16'h55);
    img[8]  = ins(0, 7, 302);
    img[9]  = ins(2, 0, 10'h3FD);
    img[10] = ins(3, 6, 0);
    img[11] = ins(3, 7, 0);
    img[12] = ins(0, 7, 303);
    img[13] = ins(2, 0, 1);
    img[14] = ins(0, 7, DONE_A);
    img[15] = ins(2, 8, 15);
    img[300] = 16'hDEAD;
    img[302] = 16'hBEEF;
    @(negedge clk);
    check("R1", mem_addr, 0, "address after mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R14", mem_en, 1'b0, "no access for mode-11 no-op");
    @(negedge clk);
    check("R2", {mem_en, mem_rw, 6'(mem_addr)}, {1'b1, 1'b1, 6'd1}, "second fetch");
    run_to_done("R13");
    check("R7", mem[300], 16'hDEAD, "immediate store is ignored");
    check("R13", mem[301], 16'd3, "program counter copied to accumulator");
    check("R13", mem[302], 16'hBEEF, "jump through accumulator skipped store");
    check("R12", mem[303], 16'd5, "flags round trip");

    // R6 R7 R9: Fibonacci loop storing through a pointer
    begin_run();
    img[0]  = ins(2, 0, 0);   img[1]  = ins(0, 7, 100);
    img[2]  = ins(2, 0, 1);   img[3]  = ins(0, 7, 101);
    img[4]  = ins(0, 0, 100); img[5]  = ins(0, 4, 101);
    img[6]  = ins(0, 7, 102); img[7]  = ins(0, 0, 101);
    img[8]  = ins(0, 7, 100); img[9]  = ins(0, 0, 102);
    img[10] = ins(0, 7, 101); img[11] = ins(1, 7, 103);
    img[12] = ins(0, 0, 103); img[13] = ins(2, 4, 1);
    img[14] = ins(0, 7, 103); img[15] = ins(0, 0, 102);
    img[16] = ins(2, 6, 200); img[17] = ins(2, 12, 4);
    img[18] = ins(2, 0, 1);   img[19] = ins(0, 7, DONE_A);
    img[20] = ins(2, 8, 20);
    img[103] = 16'd600;
    go("R9");
    begin
      int x, y, z, cnt;
      x = 0; y = 1; cnt = 0;
      do begin
        z = x + y;
        check("R6", mem[600 + cnt], z, "sequence value via pointer");
        x = y; y = z; cnt++;
      end while (z < 200);
      check("R9", mem[600 + cnt], 0, "loop exits after first value >= 200");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R3: watchdog expired act=%0d exp=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule